// File: doc/BRIEF.md
# Eight-Phase Sampling TDC Encoder

This block turns raw phase samples of a hit signal into timestamps. Each clock period it gets two 4-bit sample words per channel from two oversampling samplers. Together the two words cover eight equally spaced phases, so one fine step is one eighth of the clock period (45 degrees).

The second sampler is fed the complement of the hit, so its bits are inverted. The two samplers' phases interleave with each other. The block restores ascending phase order and removes the inversion. It then looks for the first qualified rising edge in the nine-bit window made of the last sample of the previous period followed by the eight current samples. The 3-bit position of that edge is appended to a free-running wrapping coarse counter.

Two channels share the coarse counter and its wrap marker, and each channel reports its own timestamp, valid pulse and double-hit flag. Phase generation, the input primitives and the readout are outside the block. The sample words arrive already captured in the block's clock domain.

Top module: `tdc_enc_top`

## Requirements
- R1: Phase index k counts 45-degree steps from 0 to 7. In sampler word A (true hit), bit j holds phase 2j+1. In sampler word B (complemented hit), bit j holds the inverse of phase (2j+2) mod 8, so B bit 3 carries phase 0. For channel c, word A is samp_a_i[4c+3:4c] and word B is samp_b_i[4c+3:4c].
- R2: For a word captured at a rising clock edge, the outputs appear after the next rising edge. A valid pulse that lasts one cycle reports ts = {coarse, fine}: fine sits in the low 3 bits and is the phase index of the first 1 sample of the qualified edge.
- R3: An edge that falls between phase 7 of one period and phase 0 of the next is detected. The previous period's phase-7 sample is 0, and phases 0 and 1 of the current period are 1, which gives fine = 0.
- R4: A 0-to-1 step whose first 1 sits at phase k qualifies only if phase k+1 is also 1. At k = 7 no second 1 is needed. The earliest qualified step wins, so isolated single-phase pulses are skipped.
- R5: If another 0-to-1 step appears after the reported edge in the same window, that step produces no timestamp, and dbl_o rises together with the valid pulse.
- R6: A window with no qualified rising step gives no valid pulse. This covers a steady high, a steady low and a falling edge.
- R7: The coarse field is the number of rising clock edges after reset that came before the capturing edge, taken modulo 2^CW.
- R8: wrap_o pulses for one cycle, in the output cycle of the word whose coarse value is all ones.
- R9: The channels are independent: each has its own window and history but uses the same coarse value.
- R10: During reset, and in the cycle after it, all outputs are 0. A hit that is already high when reset is released is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| samp_a_i | input | NCH*4 | True-hit sampler words, 4 bits per channel |
| samp_b_i | input | NCH*4 | Complemented-hit sampler words, 4 bits per channel |
| valid_o | output | NCH | One-cycle timestamp strobe per channel |
| ts_o | output | NCH*(CW+3) | Per-channel {coarse, fine} timestamp |
| dbl_o | output | NCH | Extra edge seen in the window of the reported hit |
| wrap_o | output | 1 | Coarse counter wrap marker |

## Verification
The bench sweeps a clean step across all eight fine bins on both channels at once, with the two channels using mirrored delays. This separates a swapped or uninverted phase lane (the fine code comes out wrong) from a channel crosstalk fault. The bin-0 case is the only one that needs the previous period's last sample, so it exposes a broken boundary path. Bubbled windows test the two-ones rule, and windows with two rising steps test the double flag. Steady high, falling and low windows must stay quiet. A hit placed just before and just after the coarse wrap checks the stamp arithmetic and the timing of wrap_o.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int unsigned NPH    = 8;
  localparam int unsigned FINE_W = 3;
  localparam int unsigned SAMP_W = NPH / 2;

  typedef struct packed {
    logic              hit;
    logic              dbl;
    logic [FINE_W-1:0] fine;
  } edge_res_t;
endpackage

// File: rtl/tdc_phase_align.sv
module tdc_phase_align
  import tdc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SAMP_W-1:0] a_i,
  input  logic [SAMP_W-1:0] b_i,
  output logic [NPH-1:0]    ph_o,
  output logic              prv_o
);
  logic [NPH-1:0] ord;
  logic [NPH-1:0] ph_q;
  logic           prv_q;

  // true path on odd phases, complemented path on even phases
  always_comb begin
    ord = '0;
    for (int j = 0; j < int'(SAMP_W); j++) begin
      ord[2*j+1]         = a_i[j];
      ord[(2*j+2) % NPH] = ~b_i[j];
    end
  end

  // reset to "high" so a hit present at reset release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '1;
      prv_q <= 1'b1;
    end else begin
      ph_q  <= ord;
      prv_q <= ph_q[NPH-1];
    end
  end

  assign ph_o  = ph_q;
  assign prv_o = prv_q;
endmodule

// File: rtl/tdc_edge_find.sv
module tdc_edge_find
  import tdc_pkg::*;
(
  input  logic [NPH-1:0] ph_i,
  input  logic           prv_i,
  output edge_res_t      res_o
);
  logic [NPH+1:0] ext;
  logic [NPH-1:0] rise;
  logic [NPH-1:0] qual;
  edge_res_t      res;

  // padding 1 above the window lets a last-phase step qualify alone
  assign ext = {1'b1, ph_i, prv_i};

  always_comb begin
    for (int k = 0; k < int'(NPH); k++) begin
      rise[k] = !ext[k] && ext[k+1];
      qual[k] = rise[k] && ext[k+2];
    end
  end

  always_comb begin
    res = '0;
    for (int k = int'(NPH) - 1; k >= 0; k--) begin
      if (qual[k]) begin
        res.hit  = 1'b1;
        res.fine = FINE_W'(k);
      end
    end
    for (int k = 0; k < int'(NPH); k++) begin
      if (res.hit && rise[k] && (k > int'(res.fine))) res.dbl = 1'b1;
    end
  end

  assign res_o = res;
endmodule

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr #(
  parameter int unsigned CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          max_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign max_o = &cnt_q;
endmodule

// File: rtl/tdc_enc_top.sv
module tdc_enc_top
  import tdc_pkg::*;
#(
  parameter  int unsigned NCH = 2,
  parameter  int unsigned CW  = 24,
  localparam int unsigned TSW = CW + FINE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCH*SAMP_W-1:0] samp_a_i,
  input  logic [NCH*SAMP_W-1:0] samp_b_i,
  output logic [NCH-1:0]        valid_o,
  output logic [NCH*TSW-1:0]    ts_o,
  output logic [NCH-1:0]        dbl_o,
  output logic                  wrap_o
);
  logic [CW-1:0]                cnt_q;
  logic                         cnt_max;
  logic [CW-1:0]                cnt_s1;
  logic                         wrap_s1;
  logic                         wrap_q;
  logic [NCH-1:0][NPH-1:0]      ph_q;
  logic [NCH-1:0]               prv_q;
  edge_res_t [NCH-1:0]          res;
  logic [NCH-1:0]               valid_q;
  logic [NCH-1:0]               dbl_q;
  logic [NCH-1:0][TSW-1:0]      ts_q;

  tdc_coarse_ctr #(.CW(CW)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt_q),
    .max_o (cnt_max)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tdc_phase_align u_align (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_i   (samp_a_i[c*SAMP_W +: SAMP_W]),
      .b_i   (samp_b_i[c*SAMP_W +: SAMP_W]),
      .ph_o  (ph_q[c]),
      .prv_o (prv_q[c])
    );

    tdc_edge_find u_find (
      .ph_i (ph_q[c]),
      .prv_i(prv_q[c]),
      .res_o(res[c])
    );
  end

  // coarse stamp follows the samples through the align register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_s1  <= '0;
      wrap_s1 <= 1'b0;
      wrap_q  <= 1'b0;
      valid_q <= '0;
      dbl_q   <= '0;
      ts_q    <= '0;
    end else begin
      cnt_s1  <= cnt_q;
      wrap_s1 <= cnt_max;
      wrap_q  <= wrap_s1;
      for (int c = 0; c < int'(NCH); c++) begin
        valid_q[c] <= res[c].hit;
        dbl_q[c]   <= res[c].hit && res[c].dbl;
        ts_q[c]    <= res[c].hit ? {cnt_s1, res[c].fine} : '0;
      end
    end
  end

  assign valid_o = valid_q;
  assign dbl_o   = dbl_q;
  assign ts_o    = ts_q;
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/tdc_enc_chk.sv
module tdc_enc_chk
  import tdc_pkg::*;
#(
  parameter  int unsigned NCH = 2,
  parameter  int unsigned CW  = 24,
  localparam int unsigned TSW = CW + FINE_W
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NCH-1:0]           valid_o,
  input logic [NCH*TSW-1:0]       ts_o,
  input logic [NCH-1:0]           dbl_o,
  input logic                     wrap_o,
  input logic [CW-1:0]            cnt_q,
  input logic [NCH-1:0][NPH-1:0]  ph_q,
  input logic [NCH-1:0]           prv_q
);
  logic run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  AST_COARSE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q == CW'($past(cnt_q) + 1'b1)); // R7

  AST_WRAP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o); // R8

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_DBL_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dbl_o[c] |-> valid_o[c]); // R5

    AST_QUIET_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prv_q[c] && (&ph_q[c])) |=> !valid_o[c]); // R6

    AST_BOUNDARY_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!prv_q[c] && ph_q[c][0] && ph_q[c][1])
        |=> (valid_o[c] && ts_o[c*TSW +: FINE_W] == '0)); // R3

    AST_WRAP_STAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap_o && valid_o[c]) |-> (&ts_o[c*TSW+FINE_W +: CW])); // R8
  end
endmodule

bind tdc_enc_top tdc_enc_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_o(valid_o),
  .ts_o   (ts_o),
  .dbl_o  (dbl_o),
  .wrap_o (wrap_o),
  .cnt_q  (cnt_q),
  .ph_q   (ph_q),
  .prv_q  (prv_q)
);

// File: tb/tb_tdc_enc_top.sv
module tb_tdc_enc_top;
  localparam int NCH = 2;
  localparam int CW  = 6;
  localparam int TSW = CW + 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NCH*4-1:0]   samp_a_i;
  logic [NCH*4-1:0]   samp_b_i;
  logic [NCH-1:0]     valid_o;
  logic [NCH*TSW-1:0] ts_o;
  logic [NCH-1:0]     dbl_o;
  logic               wrap_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  tdc_enc_top #(.NCH(NCH), .CW(CW)) dut (.*);

  // edges since reset, modulo 2^CW (R7)
  logic [CW-1:0] ref_cnt;
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ref_cnt <= '0;
    else         ref_cnt <= ref_cnt + 1'b1;

  // slot 0: driven at last negedge, slot 1: now at the outputs
  logic          earm [2];
  logic          ev   [2][NCH];
  logic [2:0]    ef   [2][NCH];
  logic          ed   [2][NCH];
  logic [CW-1:0] ecc  [2];
  string         etag [2];

  function automatic logic [3:0] to_a(input logic [7:0] p);
    for (int j = 0; j < 4; j++) to_a[j] = p[2*j+1];
  endfunction

  function automatic logic [3:0] to_b(input logic [7:0] p);
    for (int j = 0; j < 4; j++) to_b[j] = ~p[(2*j+2) % 8];
  endfunction

  task automatic check_slot();
    for (int c = 0; c < NCH; c++) begin
      logic [TSW-1:0] exp_ts;
      logic [TSW-1:0] got_ts;
      exp_ts = {ecc[1], ef[1][c]};
      got_ts = ts_o[c*TSW +: TSW];
      total++;
      if (valid_o[c] !== ev[1][c] || dbl_o[c] !== ed[1][c] ||
          (ev[1][c] && got_ts !== exp_ts)) begin
        bad++;
        $display("FAIL %s ch%0d: valid=%0b dbl=%0b ts=%0d expected valid=%0b dbl=%0b ts=%0d",
                 etag[1], c, valid_o[c], dbl_o[c], got_ts, ev[1][c], ed[1][c], exp_ts);
      end
    end
    total++;
    if (wrap_o !== (&ecc[1])) begin
      bad++;
      $display("FAIL R8 wrap: got=%0b expected=%0b", wrap_o, &ecc[1]);
    end
  endtask

  task automatic cyc(input logic [7:0] p0, input logic v0, input logic [2:0] f0, input logic d0,
                     input logic [7:0] p1, input logic v1, input logic [2:0] f1, input logic d1,
                     input string tag);
    @(negedge clk_i);
    if (earm[1]) check_slot();
    earm[1] = earm[0]; ecc[1] = ecc[0]; etag[1] = etag[0];
    for (int c = 0; c < NCH; c++) begin
      ev[1][c] = ev[0][c]; ef[1][c] = ef[0][c]; ed[1][c] = ed[0][c];
    end
    samp_a_i = {to_a(p1), to_a(p0)};
    samp_b_i = {to_b(p1), to_b(p0)};
    earm[0] = 1'b1; ecc[0] = ref_cnt; etag[0] = tag;
    ev[0][0] = v0; ef[0][0] = f0; ed[0][0] = d0;
    ev[0][1] = v1; ef[0][1] = f1; ed[0][1] = d1;
  endtask

  task automatic idle(input string tag);
    cyc(8'h00, 0, 0, 0, 8'h00, 0, 0, 0, tag);
  endtask

  initial begin
    earm[0] = 0; earm[1] = 0;
    samp_a_i = {to_a(8'hFF), to_a(8'hFF)};
    samp_b_i = {to_b(8'hFF), to_b(8'hFF)};
    repeat (3) @(negedge clk_i);
    total++;
    if (valid_o !== '0 || dbl_o !== '0 || wrap_o !== 1'b0 || ts_o !== '0) begin
      bad++;
      $display("FAIL R10 reset: valid=%0b dbl=%0b wrap=%0b ts=%0h expected all zero",
               valid_o, dbl_o, wrap_o, ts_o);
    end
    rst_ni = 1'b1;
    // hit already high at release: never reported (R10), falling edge quiet (R6)
    cyc(8'hFF, 0, 0, 0, 8'hFF, 0, 0, 0, "R10");
    cyc(8'hFF, 0, 0, 0, 8'hFF, 0, 0, 0, "R10");
    cyc(8'h00, 0, 0, 0, 8'h00, 0, 0, 0, "R6");
    // bin sweep, mirrored delays on the two channels (R1 R2 R9, bin 0 is R3)
    for (int d = 0; d < 8; d++) begin
      idle("R6");
      cyc(8'(8'hFF << d), 1, 3'(d), 0, 8'(8'hFF << (7 - d)), 1, 3'(7 - d), 0,
          (d == 0) ? "R1 R2 R3 R9" : "R1 R2 R9");
      cyc(8'hFF, 0, 0, 0, 8'hFF, 0, 0, 0, "R6");
      cyc(8'h00, 0, 0, 0, 8'h00, 0, 0, 0, "R6");
    end
    // bubbles: 0,1,0,1,1.. -> bin 3; single pulse at 5 then last phase -> bin 7 (R4)
    cyc(8'hFA, 1, 3, 0, 8'hA0, 1, 7, 0, "R4");
    cyc(8'hFF, 0, 0, 0, 8'hFF, 0, 0, 0, "R4");
    idle("R6");
    // two rising steps in one window (R5)
    cyc(8'hCC, 1, 2, 1, 8'h36, 1, 1, 1, "R5");
    idle("R5");
    // one channel only (R9)
    cyc(8'hF0, 1, 4, 0, 8'h00, 0, 0, 0, "R9");
    idle("R9");
    // around the coarse wrap (R7 R8)
    while (ref_cnt != 6'd61) idle("R7");
    idle("R7");
    cyc(8'hE0, 1, 5, 0, 8'h00, 0, 0, 0, "R7 R8");
    idle("R8");
    cyc(8'h00, 0, 0, 0, 8'hFC, 1, 2, 0, "R7");
    repeat (3) idle("R7");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      bad++;
      $display("FAIL R2 watchdog: got=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule